// File: doc/BRIEF.md
# Reference and Mode Control Sampler

This block is the control front end of a synchronizer that follows one of two timing references. It takes the external control levels: the reference choice, a two-bit operating-mode code and the enable for the time-interval-error function. It admits them only on the rising edge of the 8 kHz frame pulse that the clock section produces. From the admitted values it drives the select of the reference multiplexer, a level that enables the time-interval-error block, and three indicator outputs. Exactly one of the indicators, Normal, Holdover or Freerun, is high at any time.

The control levels arrive from outside the clock domain, so each one passes through a synchronizer of parameterised depth before the frame edge samples it. The two active-low reset pins are filtered by low-width counters running on the master clock. A low shorter than the minimum width, 300 ns by default and derived from the clock period parameter, is ignored. A qualified device reset raises a level that holds the framing and clock outputs high, and it returns the sampled controls to their defaults. A qualified reset of the time-interval-error block produces a single-cycle clear pulse, which also requests realignment of the output phase to the input phase.

Top module: `refmode_ctl_sampler`

## Requirements
- R1: After `rst_n` is low at a clock edge, the outputs are `ref_mux_sel`=0, `tie_enable`=0, `ind_freerun`=1, `ind_normal`=0, `ind_holdover`=0, `dev_rst_active`=0 and `tie_clr_pulse`=0.
- R2: On the clock edge at which `frame_pulse` is first seen high, `ref_mux_sel` takes the synchronized `ref_sel_in`. A value of 0 selects reference 0 and a value of 1 selects reference 1.
- R3: On the same edge the synchronized `mode_sel_in` sets the indicators. Code 2'b00 gives Normal, 2'b01 gives Holdover, 2'b10 gives Freerun, and 2'b11 is also treated as Freerun.
- R4: On the same edge `tie_enable` takes the synchronized `tie_en_in`: 1 enables the function and 0 disables it.
- R5: When there is no rising edge of `frame_pulse`, `ref_mux_sel`, `tie_enable` and the indicators keep their values. This holds while `frame_pulse` stays high and while it stays low.
- R6: Exactly one of `ind_normal`, `ind_holdover` and `ind_freerun` is high in every cycle.
- R7: `dev_rst_n_in` is honoured only after it has been sampled low at MIN_LOW_CYC consecutive clock edges. MIN_LOW_CYC is ceil(MIN_LOW_PS / CLK_PERIOD_PS), which is 60 by default. A shorter low never raises `dev_rst_active` and leaves the sampled controls unchanged.
- R8: While the device reset is qualified, `dev_rst_active` is 1 and the sampled controls are held at their R1 defaults, even if a frame edge arrives. Within SYNC_STAGES+3 cycles after the pin returns high, `dev_rst_active` falls to 0.
- R9: Each low of `tie_rst_n_in` that lasts at least MIN_LOW_CYC edges produces exactly one `tie_clr_pulse` that is one cycle wide. A shorter low produces none.
- R10: A control level must be applied at least SYNC_STAGES+1 clock edges before the frame edge to be taken. A level that changes in the same cycle as the frame edge is not taken, and the previous value is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| frame_pulse | input | 1 | 8 kHz frame pulse, synchronous to clk |
| ref_sel_in | input | 1 | Reference choice, asynchronous |
| mode_sel_in | input | 2 | Operating mode code, asynchronous |
| tie_en_in | input | 1 | Time-interval-error enable, asynchronous |
| dev_rst_n_in | input | 1 | Device reset pin, active low, asynchronous |
| tie_rst_n_in | input | 1 | Time-interval-error block reset pin, active low, asynchronous |
| ref_mux_sel | output | 1 | Sampled reference select |
| tie_enable | output | 1 | Sampled time-interval-error enable |
| ind_normal | output | 1 | Normal mode indicator |
| ind_holdover | output | 1 | Holdover mode indicator |
| ind_freerun | output | 1 | Freerun mode indicator |
| dev_rst_active | output | 1 | Qualified device reset; holds framing and clock outputs high |
| tie_clr_pulse | output | 1 | One-cycle clear and realign request |

## Verification
A wrong sampled register shows up at the outputs on the clock edge right after the frame edge that loaded it, and it stays wrong until the next frame edge. A long frame period can therefore hide it, so the bench checks every control combination immediately after each frame edge. A low-width counter that is off by one shows only at the exact boundary, so lows of MIN_LOW_CYC-1 and MIN_LOW_CYC edges are both applied to each reset pin. A synchronizer with the wrong depth shows when a level changes in the same cycle as the frame edge.

// File: rtl/refmode_pkg.sv
// Package: shared mode encoding for the reference and mode control sampler.
// Assumes the two-bit code from the pins; the unused code maps to Freerun.
package refmode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'b00,
        MODE_HOLDOVER = 2'b01,
        MODE_FREERUN  = 2'b10
    } op_mode_e;

    // Map a raw pin code to an operating mode.
    function automatic op_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b00:   return MODE_NORMAL;
            2'b01:   return MODE_HOLDOVER;
            default: return MODE_FREERUN;
        endcase
    endfunction

endpackage

// File: rtl/cdc_sync_bits.sv
// Module: multi-stage synchronizer for a bundle of independent level signals.
// Assumes every bit is a slow level; no bus coherency is provided.
// STAGES must be at least 2.
module cdc_sync_bits #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            // Each further stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/low_width_qual.sv
// Module: qualifies an active-low level that must stay low for MIN_CYC edges.
// Assumes low_n is already synchronous to clk. qual is high from the edge at
// which the count reaches MIN_CYC until the input returns high; pulse is high
// for exactly one cycle per qualified low.
module low_width_qual #(
    parameter int MIN_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_n,
    output logic qual,
    output logic pulse
);

    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] LIM   = CNT_W'(MIN_CYC);
    localparam logic [CNT_W-1:0] LIM_M = CNT_W'(MIN_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             pulse_q;

    // Count consecutive low cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || low_n) begin
            cnt     <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (cnt != LIM) cnt <= cnt + 1'b1;
            pulse_q <= (cnt == LIM_M);
        end
    end

    assign qual  = (cnt == LIM);
    assign pulse = pulse_q;

endmodule

// File: rtl/frame_sampler.sv
// Module: loads the synchronized control levels on each rising frame edge and
// decodes the mode into one-hot indicators. Assumes frame_pulse is
// synchronous to clk. clr (qualified device reset) has priority over loading.
module frame_sampler
    import refmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       frame_pulse,
    input  logic       ref_s,
    input  logic [1:0] mode_s,
    input  logic       tie_s,
    output logic       ref_q,
    output logic       tie_q,
    output logic [2:0] ind
);

    logic     fp_d;
    logic     fp_rise;
    op_mode_e mode_q;

    assign fp_rise = frame_pulse && !fp_d;

    // Remember the previous frame level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fp_d <= 1'b0;
        else        fp_d <= frame_pulse;
    end

    // Load the controls on a rising frame edge; clear to defaults on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ref_q  <= 1'b0;
            tie_q  <= 1'b0;
            mode_q <= MODE_FREERUN;
        end else if (fp_rise) begin
            ref_q  <= ref_s;
            tie_q  <= tie_s;
            mode_q <= decode_mode(mode_s);
        end
    end

    // One-hot indicators: ind[2]=Normal, ind[1]=Holdover, ind[0]=Freerun.
    always_comb begin
        case (mode_q)
            MODE_NORMAL:   ind = 3'b100;
            MODE_HOLDOVER: ind = 3'b010;
            default:       ind = 3'b001;
        endcase
    end

endmodule

// File: rtl/refmode_ctl_sampler.sv
// Module: top of the reference and mode control sampler. It synchronizes the
// asynchronous pins, qualifies the two active-low reset pins by width, and
// samples the controls on frame edges. Assumes clk has period CLK_PERIOD_PS
// and frame_pulse is generated in the clk domain.
module refmode_ctl_sampler #(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int MIN_LOW_PS    = 300000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_pulse,
    input  logic       ref_sel_in,
    input  logic [1:0] mode_sel_in,
    input  logic       tie_en_in,
    input  logic       dev_rst_n_in,
    input  logic       tie_rst_n_in,
    output logic       ref_mux_sel,
    output logic       tie_enable,
    output logic       ind_normal,
    output logic       ind_holdover,
    output logic       ind_freerun,
    output logic       dev_rst_active,
    output logic       tie_clr_pulse
);

    localparam int MIN_LOW_CYC = (MIN_LOW_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    logic       s_ref;
    logic [1:0] s_mode;
    logic       s_tie;
    logic       s_dev_n;
    logic       s_tie_n;
    logic       dev_pulse_unused;
    logic       tie_qual_unused;
    logic [2:0] ind;

    cdc_sync_bits #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ref_sel_in, mode_sel_in, tie_en_in}),
        .q     ({s_ref, s_mode, s_tie})
    );

    cdc_sync_bits #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dev_rst_n_in, tie_rst_n_in}),
        .q     ({s_dev_n, s_tie_n})
    );

    low_width_qual #(.MIN_CYC(MIN_LOW_CYC)) u_dev_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .low_n (s_dev_n),
        .qual  (dev_rst_active),
        .pulse (dev_pulse_unused)
    );

    low_width_qual #(.MIN_CYC(MIN_LOW_CYC)) u_tie_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .low_n (s_tie_n),
        .qual  (tie_qual_unused),
        .pulse (tie_clr_pulse)
    );

    frame_sampler u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (dev_rst_active),
        .frame_pulse (frame_pulse),
        .ref_s       (s_ref),
        .mode_s      (s_mode),
        .tie_s       (s_tie),
        .ref_q       (ref_mux_sel),
        .tie_q       (tie_enable),
        .ind         (ind)
    );

    assign ind_normal   = ind[2];
    assign ind_holdover = ind[1];
    assign ind_freerun  = ind[0];

endmodule

// File: rtl/refmode_ctl_sampler_chk.sv
// Module: property checker for the reference and mode control sampler,
// attached to the top by bind. It observes ports and synchronizer outputs.
module refmode_ctl_sampler_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_pulse,
    input logic ref_mux_sel,
    input logic tie_enable,
    input logic ind_normal,
    input logic ind_holdover,
    input logic ind_freerun,
    input logic dev_rst_active,
    input logic tie_clr_pulse,
    input logic s_ref,
    input logic s_dev_n
);

    // R6: exactly one indicator is high.
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({ind_normal, ind_holdover, ind_freerun}));

    // R5: with the frame pulse low and no device reset, the state holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && !dev_rst_active) |=>
            $stable({ref_mux_sel, tie_enable, ind_normal, ind_holdover, ind_freerun}));

    // R2: a frame edge loads the synchronized reference choice.
    a_r2_ref_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_pulse) && !dev_rst_active) |=> (ref_mux_sel == $past(s_ref)));

    // R8: a qualified device reset forces the defaults on the next cycle.
    a_r8_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_active |=> (ind_freerun && !ref_mux_sel && !tie_enable));

    // R7: the device reset is only active after a low on the synchronized pin.
    a_r7_low_seen: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst_active |-> !$past(s_dev_n));

    // R9: the clear pulse lasts one cycle.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tie_clr_pulse |=> !tie_clr_pulse);

endmodule

bind refmode_ctl_sampler refmode_ctl_sampler_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_pulse    (frame_pulse),
    .ref_mux_sel    (ref_mux_sel),
    .tie_enable     (tie_enable),
    .ind_normal     (ind_normal),
    .ind_holdover   (ind_holdover),
    .ind_freerun    (ind_freerun),
    .dev_rst_active (dev_rst_active),
    .tie_clr_pulse  (tie_clr_pulse),
    .s_ref          (s_ref),
    .s_dev_n        (s_dev_n)
);

// File: tb/refmode_ctl_sampler_bench.sv
// Bench: vector table for the sampled controls, then directed tests for reset,
// edge handling, synchronizer latency and reset-width qualification.
module refmode_ctl_sampler_bench;

    localparam int MIN_LOW = 60;   // 300000 ps / 5000 ps

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       ref_sel_in = 1'b0;
    logic [1:0] mode_sel_in = 2'b00;
    logic       tie_en_in = 1'b0;
    logic       dev_rst_n_in = 1'b1;
    logic       tie_rst_n_in = 1'b1;
    logic       ref_mux_sel, tie_enable, ind_normal, ind_holdover, ind_freerun;
    logic       dev_rst_active, tie_clr_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tie_pulses = 0;
    bit dev_seen = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    refmode_ctl_sampler u_refmode_ctl_sampler (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .ref_sel_in(ref_sel_in), .mode_sel_in(mode_sel_in), .tie_en_in(tie_en_in),
        .dev_rst_n_in(dev_rst_n_in), .tie_rst_n_in(tie_rst_n_in),
        .ref_mux_sel(ref_mux_sel), .tie_enable(tie_enable),
        .ind_normal(ind_normal), .ind_holdover(ind_holdover), .ind_freerun(ind_freerun),
        .dev_rst_active(dev_rst_active), .tie_clr_pulse(tie_clr_pulse)
    );

    // Vector: [8]ref [7:6]mode [5]tie | [4]exp ref [3:1]exp ind {N,H,F} [0]exp tie
    localparam logic [8:0] VEC [8] = '{
        9'b0_00_0_0_100_0,
        9'b1_00_1_1_100_1,
        9'b0_01_1_0_010_1,
        9'b1_01_0_1_010_0,
        9'b0_10_0_0_001_0,
        9'b1_10_1_1_001_1,
        9'b0_11_1_0_001_1,
        9'b1_11_0_1_001_0
    };

    // Monitor qualified reset level and clear pulses away from the active edge.
    always @(negedge clk) begin
        if (dev_rst_active) dev_seen = 1'b1;
        if (tie_clr_pulse) tie_pulses++;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] inds();
        return {ind_normal, ind_holdover, ind_freerun};
    endfunction

    task automatic frame_edge();
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
    endtask

    task automatic pin_low(input bit dev, input int n);
        if (dev) dev_rst_n_in = 1'b0; else tie_rst_n_in = 1'b0;
        repeat (n) @(negedge clk);
        dev_rst_n_in = 1'b1;
        tie_rst_n_in = 1'b1;
        repeat (SETTLE) @(negedge clk);
    endtask

    localparam int SETTLE = 6;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 inds", 8'(inds()), 8'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ref", 8'(ref_mux_sel), 8'h0);
        chk("R1 tie", 8'(tie_enable), 8'h0);
        chk("R1 inds", 8'(inds()), 8'h1);
        chk("R1 dev", 8'(dev_rst_active), 8'h0);
        chk("R1 tiepulse", 8'(tie_clr_pulse), 8'h0);

        // Vector table: inputs settle through the synchronizer, then one edge.
        for (int i = 0; i < 8; i++) begin
            ref_sel_in  = VEC[i][8];
            mode_sel_in = VEC[i][7:6];
            tie_en_in   = VEC[i][5];
            repeat (4) @(negedge clk);
            frame_edge();
            chk("R2 ref", 8'(ref_mux_sel), 8'(VEC[i][4]));
            chk("R3 mode", 8'(inds()), 8'(VEC[i][3:1]));
            chk("R4 tie", 8'(tie_enable), 8'(VEC[i][0]));
            chk("R6 onehot", 8'($countones(inds())), 8'h1);
            repeat (2) @(negedge clk);
        end

        // R5: frame held high, inputs change; no second load.
        frame_pulse = 1'b1;
        @(negedge clk);
        ref_sel_in = 1'b0; mode_sel_in = 2'b00; tie_en_in = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 high ref", 8'(ref_mux_sel), 8'h1);
        chk("R5 high inds", 8'(inds()), 8'h1);
        chk("R5 high tie", 8'(tie_enable), 8'h0);
        frame_pulse = 1'b0;
        repeat (10) @(negedge clk);
        chk("R5 low ref", 8'(ref_mux_sel), 8'h1);
        chk("R5 low tie", 8'(tie_enable), 8'h0);

        // R10: change in the same cycle as the frame edge takes the old value.
        ref_sel_in = 1'b1;
        frame_edge();
        chk("R10 ref", 8'(ref_mux_sel), 8'h0);
        chk("R10 inds", 8'(inds()), 8'h4);
        repeat (4) @(negedge clk);
        frame_edge();
        chk("R10 later ref", 8'(ref_mux_sel), 8'h1);

        // R7: device reset one edge short of the minimum is ignored.
        dev_seen = 1'b0;
        pin_low(1'b1, MIN_LOW - 1);
        chk("R7 short dev", 8'(dev_seen), 8'h0);
        chk("R7 short ref", 8'(ref_mux_sel), 8'h1);
        chk("R7 short tie", 8'(tie_enable), 8'h1);
        // R7: exactly the minimum is honoured.
        pin_low(1'b1, MIN_LOW);
        chk("R7 exact dev", 8'(dev_seen), 8'h1);
        chk("R8 released", 8'(dev_rst_active), 8'h0);
        chk("R8 ref", 8'(ref_mux_sel), 8'h0);
        chk("R8 inds", 8'(inds()), 8'h1);
        chk("R8 tie", 8'(tie_enable), 8'h0);

        // R8: frame edge during a qualified reset is ignored.
        ref_sel_in = 1'b1; mode_sel_in = 2'b01; tie_en_in = 1'b1;
        dev_rst_n_in = 1'b0;
        repeat (MIN_LOW + 10) @(negedge clk);
        chk("R8 active", 8'(dev_rst_active), 8'h1);
        frame_edge();
        @(negedge clk);
        chk("R8 held ref", 8'(ref_mux_sel), 8'h0);
        chk("R8 held inds", 8'(inds()), 8'h1);
        dev_rst_n_in = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk("R8 release", 8'(dev_rst_active), 8'h0);

        // R9: clear pulse qualification.
        tie_pulses = 0;
        pin_low(1'b0, MIN_LOW - 1);
        chk("R9 short", 8'(tie_pulses), 8'h0);
        pin_low(1'b0, MIN_LOW);
        chk("R9 exact", 8'(tie_pulses), 8'h1);
        tie_pulses = 0;
        pin_low(1'b0, 3 * MIN_LOW);
        chk("R9 long", 8'(tie_pulses), 8'h1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule